// File: doc/BRIEF.md
# Daisy-Chain Interrupt Requester Node

This block is the device-side logic that lets one peripheral ask for service on a shared bus with vectored interrupts. A local interrupt pulse is latched as a pending request, and the node then pulls the shared request line low through an open-drain drive enable. The processor answers with an acknowledge signal that runs through every device in a chain. Each node decides on the first cycle it sees acknowledge whether to hand it to its downstream neighbour or keep it.

A node that keeps the acknowledge places its configured 8-bit vector on the bus data lines. After a fixed number of setup cycles it lets go of the request line while acknowledge is still asserted. That release tells the processor the vector can be read, so no separate strobe is needed. The node keeps the vector on the bus until acknowledge goes away. It then releases the data lines and returns to idle.

A node with nothing pending passes acknowledge straight through with no delay. A request that arrives while acknowledge is already passing through is held back until acknowledge drops. This keeps the node from disturbing the request line while another device is being served.

Top module: `irq_chain_node`

## Requirements
- R1: After reset `req_oe`, `vec_oe` and `ack_out` are 0 and `vec_data` is all zeros.
- R2: A one-cycle `irq_pulse` while idle with nothing pending makes `req_oe` 1 from the next clock edge.
- R3: With no request pending and no service under way, `ack_out` equals `ack_in` in the same cycle, and `ack_out` is never 1 while `ack_in` is 0.
- R4: When `ack_in` is first seen while a request is pending, `ack_out` stays 0 from that cycle until the service ends.
- R5: On the edge after a won acknowledge, `vec_oe` goes to 1 with `req_oe` still 1. `req_oe` then stays 1 for `SETUP_CYCLES` cycles with the vector valid, and falls while `ack_in` is still 1.
- R6: The vector stays driven while `ack_in` is 1. On the edge after `ack_in` goes to 0, `vec_oe` and `req_oe` are 0 and the pending request is cleared.
- R7: A pulse that arrives while acknowledge is being passed through does not raise `req_oe`. `ack_out` keeps following `ack_in`, and `req_oe` goes to 1 on the edge after `ack_in` drops.
- R8: If a pulse and the first cycle of `ack_in` coincide with nothing pending, the acknowledge is passed on in that cycle and the request is raised only after `ack_in` drops.
- R9: Any number of pulses that arrive while a request is pending, including during service, give exactly one service. After it, `req_oe` stays 0.
- R10: `vec_data` is all zeros whenever `vec_oe` is 0.
- R11: The driven vector equals `vec_cfg` as sampled on the edge that starts the service, and it stays stable even if `vec_cfg` changes during the service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pulse | input | 1 | Local interrupt event, one cycle high |
| vec_cfg | input | VEC_W | Static vector setting, switch-style |
| ack_in | input | 1 | Acknowledge from upstream neighbour |
| ack_out | output | 1 | Acknowledge to downstream neighbour |
| req_oe | output | 1 | Drive enable for the open-drain shared request line |
| vec_oe | output | 1 | Output enable for the data lines |
| vec_data | output | VEC_W | Vector value for the data lines |

## Verification
Two functions can land in the same cycle: latching a new local pulse, and making the pass-or-block decision on the first cycle of acknowledge. The bench causes this by raising `irq_pulse` and `ack_in` in the same cycle while nothing is pending. It passes if `ack_out` rises in that same cycle, `req_oe` stays low while acknowledge is passing, and `req_oe` comes up on the edge after `ack_in` drops. The second overlap is a pulse that arrives during the last cycle of a service. It must be merged into that service and must not start a new request.

// File: rtl/irq_node_pkg.sv
package irq_node_pkg;

  typedef enum logic [1:0] {
    ND_IDLE  = 2'd0,
    ND_PASS  = 2'd1,
    ND_DRIVE = 2'd2,
    ND_HOLD  = 2'd3
  } node_state_e;

  // acknowledge forwarded downstream for a given state and pending flag
  function automatic logic grant_passes(node_state_e st, logic pend, logic ack);
    logic open_path;
    open_path = (st == ND_PASS) || ((st == ND_IDLE) && !pend);
    return ack && open_path;
  endfunction

  // request line pulled while waiting or while the vector settles
  function automatic logic request_driven(node_state_e st, logic pend);
    return ((st == ND_IDLE) && pend) || (st == ND_DRIVE);
  endfunction

  // data lines owned by this node
  function automatic logic vector_window(node_state_e st);
    return (st == ND_DRIVE) || (st == ND_HOLD);
  endfunction

endpackage

// File: rtl/irq_pending_latch.sv
module irq_pending_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  input  logic clear,
  output logic pend,
  output logic merged
);

  logic pend_q;

  // clear only happens while pending, so a coincident pulse is a merge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (clear) begin
      pend_q <= 1'b0;
    end else if (pulse) begin
      pend_q <= 1'b1;
    end
  end

  assign pend   = pend_q;
  assign merged = pulse && pend_q;

endmodule

// File: rtl/irq_grant_fsm.sv
module irq_grant_fsm
  import irq_node_pkg::*;
#(
  parameter int SETUP_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ack_in,
  input  logic        pend,
  output node_state_e state,
  output logic        ack_out,
  output logic        won,
  output logic        passed,
  output logic        done
);

  localparam int CNT_W = (SETUP_CYCLES < 2) ? 1 : $clog2(SETUP_CYCLES + 1);

  node_state_e state_q, state_d;
  logic        setup_last;
  logic        cnt_clr;

  generate
    if (SETUP_CYCLES <= 1) begin : g_single
      assign setup_last = 1'b1;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_clr) begin
          cnt_q <= '0;
        end else if (state_q == ND_DRIVE) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      assign setup_last = (cnt_q == CNT_W'(SETUP_CYCLES - 1));
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    unique case (state_q)
      ND_IDLE: begin
        cnt_clr = 1'b1;
        if (ack_in) state_d = pend ? ND_DRIVE : ND_PASS;
      end
      ND_PASS: begin
        if (!ack_in) state_d = ND_IDLE;
      end
      ND_DRIVE: begin
        if (!ack_in)        state_d = ND_IDLE;
        else if (setup_last) state_d = ND_HOLD;
      end
      ND_HOLD: begin
        if (!ack_in) state_d = ND_IDLE;
      end
      default: state_d = ND_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ND_IDLE;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign ack_out = grant_passes(state_q, pend, ack_in);
  assign won     = (state_q == ND_IDLE) && ack_in && pend;
  assign passed  = (state_q == ND_IDLE) && ack_in && !pend;
  assign done    = vector_window(state_q) && !ack_in;

endmodule

// File: rtl/irq_vector_driver.sv
module irq_vector_driver #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic [VEC_W-1:0] cfg,
  output logic             oe,
  output logic [VEC_W-1:0] data
);

  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vec_q <= '0;
    else if (load) vec_q <= cfg;
  end

  assign oe   = active;
  assign data = active ? vec_q : '0;

endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
  import irq_node_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int SETUP_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pulse,
  input  logic [VEC_W-1:0] vec_cfg,
  input  logic             ack_in,
  output logic             ack_out,
  output logic             req_oe,
  output logic             vec_oe,
  output logic [VEC_W-1:0] vec_data
);

  node_state_e st;
  logic        pend;
  logic        ev_pulse_merged;
  logic        ev_grant_won;
  logic        ev_grant_passed;
  logic        ev_serve_done;
  logic        ev_passing;

  irq_pending_latch u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .pulse  (irq_pulse),
    .clear  (ev_serve_done),
    .pend   (pend),
    .merged (ev_pulse_merged)
  );

  irq_grant_fsm #(.SETUP_CYCLES(SETUP_CYCLES)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_in  (ack_in),
    .pend    (pend),
    .state   (st),
    .ack_out (ack_out),
    .won     (ev_grant_won),
    .passed  (ev_grant_passed),
    .done    (ev_serve_done)
  );

  irq_vector_driver #(.VEC_W(VEC_W)) u_vec (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_grant_won),
    .active (vector_window(st)),
    .cfg    (vec_cfg),
    .oe     (vec_oe),
    .data   (vec_data)
  );

  assign ev_passing = (st == ND_PASS);
  assign req_oe     = request_driven(st, pend);

endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_pulse,
  input logic             ack_in,
  input logic             ack_out,
  input logic             req_oe,
  input logic             vec_oe,
  input logic [VEC_W-1:0] vec_data,
  input logic             ev_grant_won,
  input logic             ev_grant_passed,
  input logic             ev_serve_done,
  input logic             ev_passing,
  input logic             ev_pulse_merged
);

  p_no_phantom_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> ack_in);

  p_blocked_while_owning_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> !ack_out);

  p_win_drives_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant_won |=> (vec_oe && req_oe));

  p_release_with_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_oe) && $past(ack_in)) |-> vec_oe);

  p_done_frees_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_serve_done |=> (!vec_oe && !req_oe));

  p_quiet_when_passing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_passing |-> !req_oe);

  p_coincident_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_grant_passed && irq_pulse) |=> (ev_passing && !req_oe));

  p_merge_no_extra_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse_merged && ev_serve_done) |=> !req_oe);

  p_data_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe |-> (vec_data == '0));

  p_vector_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe && $past(vec_oe)) |-> $stable(vec_data));

endmodule

bind irq_chain_node irq_chain_node_chk #(.VEC_W(VEC_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .irq_pulse       (irq_pulse),
  .ack_in          (ack_in),
  .ack_out         (ack_out),
  .req_oe          (req_oe),
  .vec_oe          (vec_oe),
  .vec_data        (vec_data),
  .ev_grant_won    (ev_grant_won),
  .ev_grant_passed (ev_grant_passed),
  .ev_serve_done   (ev_serve_done),
  .ev_passing      (ev_passing),
  .ev_pulse_merged (ev_pulse_merged)
);

// File: tb/irq_chain_node_bench.sv
module irq_chain_node_bench;

  localparam int VEC_W = 8;
  localparam int SETUP = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             irq_pulse = 1'b0;
  logic [VEC_W-1:0] vec_cfg = 8'h5A;
  logic             ack_in = 1'b0;
  logic             ack_out;
  logic             req_oe;
  logic             vec_oe;
  logic [VEC_W-1:0] vec_data;
  logic             ext_req = 1'b0;
  logic             bus_irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // wired-OR of open-drain request drivers on the shared line
  assign bus_irq = req_oe | ext_req;

  irq_chain_node #(.VEC_W(VEC_W), .SETUP_CYCLES(SETUP)) u_irq_chain_node (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pulse (irq_pulse),
    .vec_cfg   (vec_cfg),
    .ack_in    (ack_in),
    .ack_out   (ack_out),
    .req_oe    (req_oe),
    .vec_oe    (vec_oe),
    .vec_data  (vec_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_once();
    irq_pulse = 1'b1;
    step();
    irq_pulse = 1'b0;
  endtask

  // run a full service starting with req_oe high at a negedge
  task automatic serve(logic [VEC_W-1:0] exp_vec, string tag, bit pulse_late);
    ack_in = 1'b1;
    #1 chk({tag, " R4 ack blocked"}, ack_out, 0);
    for (int i = 0; i < SETUP; i++) begin
      step();
      chk({tag, " R5 req held"}, req_oe, 1);
      chk({tag, " R5 vec on"}, vec_oe, 1);
      chk({tag, " R11 vec value"}, vec_data, exp_vec);
    end
    step();
    chk({tag, " R5 req released"}, req_oe, 0);
    chk({tag, " R5 vec still on"}, vec_oe, 1);
    chk({tag, " R4 ack still blocked"}, ack_out, 0);
    step(2);
    chk({tag, " R6 vec kept"}, vec_data, exp_vec);
    ack_in = 1'b0;
    if (pulse_late) irq_pulse = 1'b1;
    step();
    irq_pulse = 1'b0;
    chk({tag, " R6 vec off"}, vec_oe, 0);
    chk({tag, " R10 data zero"}, vec_data, 0);
    chk({tag, " R6 req off"}, req_oe, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(2);
    chk("R1 req_oe", req_oe, 0);
    chk("R1 vec_oe", vec_oe, 0);
    chk("R1 ack_out", ack_out, 0);
    chk("R1 vec_data", vec_data, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_pass_idle();
    ack_in = 1'b1;
    #1 chk("R3 pass same cycle", ack_out, 1);
    step(3);
    chk("R3 pass held", ack_out, 1);
    chk("R3 no request", req_oe, 0);
    ack_in = 1'b0;
    #1 chk("R3 pass drop", ack_out, 0);
    step();
  endtask

  task automatic t_single_service();
    ext_req = 1'b1;
    pulse_once();
    chk("R2 request raised", req_oe, 1);
    serve(8'h5A, "single", 1'b0);
    chk("R5 wired line held by other", bus_irq, 1);
    ext_req = 1'b0;
    step(3);
    chk("R9 idle after service", req_oe, 0);
  endtask

  task automatic t_late_request();
    ack_in = 1'b1;
    step();
    pulse_once();
    chk("R7 no request while passing", req_oe, 0);
    chk("R7 ack still passes", ack_out, 1);
    step();
    chk("R7 still quiet", req_oe, 0);
    ack_in = 1'b0;
    #1 chk("R7 ack follows drop", ack_out, 0);
    step();
    chk("R7 request after drop", req_oe, 1);
    serve(8'h5A, "late", 1'b0);
  endtask

  task automatic t_same_cycle();
    ack_in = 1'b1;
    irq_pulse = 1'b1;
    #1 chk("R8 coincident passes", ack_out, 1);
    step();
    irq_pulse = 1'b0;
    chk("R8 request held off", req_oe, 0);
    chk("R8 ack keeps passing", ack_out, 1);
    ack_in = 1'b0;
    step();
    chk("R8 request after drop", req_oe, 1);
    serve(8'h5A, "coincide", 1'b0);
  endtask

  task automatic t_merge();
    pulse_once();
    step();
    pulse_once();
    pulse_once();
    chk("R9 one request", req_oe, 1);
    serve(8'h5A, "merge", 1'b1);
    step(4);
    chk("R9 no second service", req_oe, 0);
    chk("R9 no vector", vec_oe, 0);
  endtask

  task automatic t_vector_capture();
    vec_cfg = 8'hC3;
    pulse_once();
    ack_in = 1'b1;
    step();
    vec_cfg = 8'h11;
    chk("R11 captured vector", vec_data, 8'hC3);
    step();
    chk("R11 ignores cfg change", vec_data, 8'hC3);
    step(2);
    chk("R11 stable in hold", vec_data, 8'hC3);
    ack_in = 1'b0;
    step();
    chk("R10 zero after service", vec_data, 0);
    pulse_once();
    serve(8'h11, "newcfg", 1'b0);
  endtask

  initial begin
    step();
    t_reset();
    t_pass_idle();
    t_single_service();
    t_late_request();
    t_same_cycle();
    t_merge();
    t_vector_capture();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule